// File: doc/BRIEF.md
# Card Memory Window Decoder

This block decides whether a 32-bit host memory address falls inside one of a small bank of programmable memory windows belonging to a single card socket. If it does, the block reports which window matched and the card-side address. It also reports the attributes that shape the card cycle: the data width, the attribute or common space, whether a write must be blocked, and which of two timer sets governs the access.

Each window is described by four things:
- a page byte, compared with host address bits 31-24;
- an inclusive start and end bound, at 4-Kbyte granularity, compared with host bits 23-12;
- a 14-bit offset, added to host bits 25-12 to form the card address;
- a control byte.

An enable mask gates each window. Software programs all windows through a narrow byte-wide write port. A lookup is presented with `host_valid`, and its result appears on the outputs one clock later.

Overlapping windows are a configuration error. Even so, the result stays deterministic: the lowest-numbered enabled window wins, and a multi-hit flag is raised.

Top module: `cmw_decoder`

## Requirements
- R1: After reset every window field and every enable bit is zero, and all decode outputs are zero, so no address hits even while `host_valid` is high.
- R2: An enabled window hits when its page byte equals `host_addr[31:24]` and start <= `host_addr[23:12]` <= end, with both bounds inclusive.
- R3: A window whose enable bit is clear never hits, whatever its address fields hold.
- R4: When several enabled windows hit, `dec_win` reports the lowest index and `dec_multi` is 1; with a single hit `dec_multi` is 0.
- R5: On a hit, `dec_card_addr[25:12]` = (`host_addr[25:12]` + window offset) mod 2^14 and `dec_card_addr[11:0]` = `host_addr[11:0]`.
- R6: On a hit with `host_write`=1 through a window whose write-protect bit is set, `dec_wr_block` is 1. Reads through that window hit with `dec_wr_block`=0.
- R7: `dec_timer1` is 0 when the window's 2-bit timer code is 00, and 1 for codes 01, 10 and 11.
- R8: `dec_wide` and `dec_attr` copy the matching window's size bit and space bit.
- R9: Outputs are registered: a lookup sampled at a clock edge is visible after that edge. When there is no hit, every decode output is zero.
- R10: A write with `cfg_we`=1 and `cfg_win` < 5 updates one byte of that window, selected by `cfg_field`:
  - 0: start[7:0], holding addr bits 19-12
  - 1: start[11:8] from data[3:0]
  - 2: end[7:0]
  - 3: end[11:8] from data[3:0]
  - 4: offset[7:0]
  - 5: offset[13:8] from data[5:0]
  - 6: page byte
  - 7: control byte, laid out as data[0] size (1 = 16-bit), data[1] space (1 = attribute), data[2] write protect, data[4:3] timer code

  A write with `cfg_win` >= 5 and `cfg_field`=0 loads the enable mask from data[4:0], where bit w enables window w.
- R11: With `host_valid`=0 the next cycle shows no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_win | input | 3 | Window select; values >= 5 select the enable mask |
| cfg_field | input | 3 | Field select within the window |
| cfg_data | input | 8 | Configuration write data |
| host_valid | input | 1 | Lookup request |
| host_write | input | 1 | Lookup is a write |
| host_addr | input | 32 | Host memory address |
| dec_hit | output | 1 | An enabled window matched |
| dec_win | output | 3 | Index of the reported window |
| dec_card_addr | output | 26 | Translated card address |
| dec_wide | output | 1 | 16-bit card access |
| dec_attr | output | 1 | Attribute space access |
| dec_wr_block | output | 1 | Write refused by write protect |
| dec_timer1 | output | 1 | Timer set 1 selected |
| dec_multi | output | 1 | More than one enabled window matched |

## Verification
The main decode is swept page by page over a stretch of host address space. That stretch covers both edges of every bound, a region where two windows overlap, a single-page window, the top page of the 4-Gbyte space and a disabled window that spans everything. This separates off-by-one bound errors, priority errors and faulty enable gating.

The offsets chosen make the card-address sum wrap past 2^14, which separates modulo arithmetic from a carry into the wrong bits. Reads alternate with writes so that write protection shows up only on writes, and each timer code is tried once.

Enable-mask rewrites and lookups with `host_valid` low confirm that nothing decodes without both enable and request.

// File: rtl/cmw_pkg.sv
package cmw_pkg;
    localparam int PAGE_W = 8;
    localparam int BND_W  = 12;
    localparam int OFF_W  = 14;
    localparam int CARD_W = 26;
    localparam int TSEL_W = 2;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [BND_W-1:0]  lo;
        logic [BND_W-1:0]  hi;
        logic [OFF_W-1:0]  off;
        logic              wide;
        logic              attr;
        logic              wprot;
        logic [TSEL_W-1:0] tsel;
    } win_cfg_t;
endpackage

// File: rtl/cmw_window.sv
module cmw_window
    import cmw_pkg::*;
(
    input  win_cfg_t          cfg,
    input  logic              en,
    input  logic [31:12]      addr_hi,
    output logic              match,
    output logic [OFF_W-1:0]  card_hi
);
    logic page_ok, lo_ok, hi_ok;

    always_comb begin
        page_ok = (cfg.page == addr_hi[31:24]);
        lo_ok   = (addr_hi[23:12] >= cfg.lo);
        hi_ok   = (addr_hi[23:12] <= cfg.hi);
        match   = en & page_ok & lo_ok & hi_ok;
        card_hi = addr_hi[25:12] + cfg.off;
    end
endmodule

// File: rtl/cmw_prio.sv
module cmw_prio #(
    parameter int N  = 5,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  hits,
    output logic          any,
    output logic          multi,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int w = N - 1; w >= 0; w--) begin
            if (hits[w]) idx = IW'(w);
        end
        any   = |hits;
        multi = ($countones(hits) > 1);
    end
endmodule

// File: rtl/cmw_decoder.sv
module cmw_decoder
    import cmw_pkg::*;
#(
    parameter int NUM_WIN = 5,
    localparam int IW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
    localparam int CW = $clog2(NUM_WIN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CW-1:0]     cfg_win,
    input  logic [2:0]        cfg_field,
    input  logic [7:0]        cfg_data,
    input  logic              host_valid,
    input  logic              host_write,
    input  logic [31:0]       host_addr,
    output logic              dec_hit,
    output logic [IW-1:0]     dec_win,
    output logic [CARD_W-1:0] dec_card_addr,
    output logic              dec_wide,
    output logic              dec_attr,
    output logic              dec_wr_block,
    output logic              dec_timer1,
    output logic              dec_multi
);
    typedef struct packed {
        logic              hit;
        logic [IW-1:0]     win;
        logic [CARD_W-1:0] card;
        logic              wide;
        logic              attr;
        logic              wblk;
        logic              t1;
        logic              multi;
    } out_t;

    typedef struct packed {
        win_cfg_t [NUM_WIN-1:0] wins;
        logic [NUM_WIN-1:0]     en;
        out_t                   o;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_WIN-1:0] hits;
    logic [OFF_W-1:0]   card_hi [NUM_WIN];
    logic               any_hit, multi_hit;
    logic [IW-1:0]      pick;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        cmw_window u_win (
            .cfg     (st_q.wins[g]),
            .en      (st_q.en[g]),
            .addr_hi (host_addr[31:12]),
            .match   (hits[g]),
            .card_hi (card_hi[g])
        );
    end

    cmw_prio #(.N(NUM_WIN)) u_prio (
        .hits  (hits),
        .any   (any_hit),
        .multi (multi_hit),
        .idx   (pick)
    );

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            if (cfg_win >= CW'(NUM_WIN)) begin
                if (cfg_field == 3'd0) st_d.en = cfg_data[NUM_WIN-1:0];
            end else begin
                for (int w = 0; w < NUM_WIN; w++) begin
                    if (cfg_win == CW'(w)) begin
                        case (cfg_field)
                            3'd0: st_d.wins[w].lo[7:0]   = cfg_data;
                            3'd1: st_d.wins[w].lo[11:8]  = cfg_data[3:0];
                            3'd2: st_d.wins[w].hi[7:0]   = cfg_data;
                            3'd3: st_d.wins[w].hi[11:8]  = cfg_data[3:0];
                            3'd4: st_d.wins[w].off[7:0]  = cfg_data;
                            3'd5: st_d.wins[w].off[13:8] = cfg_data[5:0];
                            3'd6: st_d.wins[w].page      = cfg_data;
                            default: begin
                                st_d.wins[w].wide  = cfg_data[0];
                                st_d.wins[w].attr  = cfg_data[1];
                                st_d.wins[w].wprot = cfg_data[2];
                                st_d.wins[w].tsel  = cfg_data[4:3];
                            end
                        endcase
                    end
                end
            end
        end

        st_d.o = '0;
        if (host_valid && any_hit) begin
            st_d.o.hit   = 1'b1;
            st_d.o.win   = pick;
            st_d.o.multi = multi_hit;
            for (int w = 0; w < NUM_WIN; w++) begin
                if (pick == IW'(w)) begin
                    st_d.o.card = {card_hi[w], host_addr[11:0]};
                    st_d.o.wide = st_q.wins[w].wide;
                    st_d.o.attr = st_q.wins[w].attr;
                    st_d.o.wblk = host_write & st_q.wins[w].wprot;
                    st_d.o.t1   = |st_q.wins[w].tsel;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dec_hit       = st_q.o.hit;
    assign dec_win       = st_q.o.win;
    assign dec_card_addr = st_q.o.card;
    assign dec_wide      = st_q.o.wide;
    assign dec_attr      = st_q.o.attr;
    assign dec_wr_block  = st_q.o.wblk;
    assign dec_timer1    = st_q.o.t1;
    assign dec_multi     = st_q.o.multi;
endmodule

// File: rtl/cmw_checker.sv
module cmw_checker #(
    parameter int NUM_WIN = 5,
    localparam int IW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_valid,
    input logic          host_write,
    input logic [31:0]   host_addr,
    input logic          dec_hit,
    input logic [IW-1:0] dec_win,
    input logic [25:0]   dec_card_addr,
    input logic          dec_wide,
    input logic          dec_attr,
    input logic          dec_wr_block,
    input logic          dec_timer1,
    input logic          dec_multi
);
    assert_hit_needs_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dec_hit |-> $past(host_valid));

    assert_multi_implies_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_multi |-> dec_hit);

    assert_win_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_hit |-> (int'(dec_win) < NUM_WIN));

    assert_idle_outputs_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_hit |-> (dec_card_addr == '0 && dec_win == '0 && !dec_wide && !dec_attr
                      && !dec_wr_block && !dec_timer1 && !dec_multi));

    assert_low_bits_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_hit |-> (dec_card_addr[11:0] == $past(host_addr[11:0])));

    assert_block_only_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_wr_block |-> (dec_hit && $past(host_write)));
endmodule

bind cmw_decoder cmw_checker #(.NUM_WIN(NUM_WIN)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_valid    (host_valid),
    .host_write    (host_write),
    .host_addr     (host_addr),
    .dec_hit       (dec_hit),
    .dec_win       (dec_win),
    .dec_card_addr (dec_card_addr),
    .dec_wide      (dec_wide),
    .dec_attr      (dec_attr),
    .dec_wr_block  (dec_wr_block),
    .dec_timer1    (dec_timer1),
    .dec_multi     (dec_multi)
);

// File: tb/sim_cmw_decoder.sv
module sim_cmw_decoder;
    localparam int NW = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_win = '0;
    logic [2:0]  cfg_field = '0;
    logic [7:0]  cfg_data = '0;
    logic        host_valid = 1'b0;
    logic        host_write = 1'b0;
    logic [31:0] host_addr = '0;
    logic        dec_hit, dec_wide, dec_attr, dec_wr_block, dec_timer1, dec_multi;
    logic [2:0]  dec_win;
    logic [25:0] dec_card_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0]  m_page [NW];
    logic [11:0] m_lo   [NW];
    logic [11:0] m_hi   [NW];
    logic [13:0] m_off  [NW];
    logic [7:0]  m_ctl  [NW];
    logic [4:0]  m_en;

    always #4 clk = ~clk;

    cmw_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win),
        .cfg_field(cfg_field), .cfg_data(cfg_data), .host_valid(host_valid),
        .host_write(host_write), .host_addr(host_addr), .dec_hit(dec_hit),
        .dec_win(dec_win), .dec_card_addr(dec_card_addr), .dec_wide(dec_wide),
        .dec_attr(dec_attr), .dec_wr_block(dec_wr_block), .dec_timer1(dec_timer1),
        .dec_multi(dec_multi)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] w, input logic [2:0] f, input logic [7:0] d);
        cfg_we = 1'b1; cfg_win = w; cfg_field = f; cfg_data = d;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_en(input logic [4:0] m);
        m_en = m;
        wr(3'd7, 3'd0, {3'b000, m});
    endtask

    task automatic set_win(input int w, input logic [7:0] pg, input logic [11:0] lo,
                           input logic [11:0] hi, input logic [13:0] off, input logic [7:0] ctl);
        m_page[w] = pg; m_lo[w] = lo; m_hi[w] = hi; m_off[w] = off; m_ctl[w] = ctl;
        wr(3'(w), 3'd0, lo[7:0]);
        wr(3'(w), 3'd1, {4'h0, lo[11:8]});
        wr(3'(w), 3'd2, hi[7:0]);
        wr(3'(w), 3'd3, {4'h0, hi[11:8]});
        wr(3'(w), 3'd4, off[7:0]);
        wr(3'(w), 3'd5, {2'b00, off[13:8]});
        wr(3'(w), 3'd6, pg);
        wr(3'(w), 3'd7, ctl);
    endtask

    // R2 R3 R4 R5 R6 R7 R8 R9: full lookup compared to an arithmetic model
    task automatic probe(input logic [31:0] a, input logic wr_n, input logic vld);
        int first = -1;
        int cnt = 0;
        logic [25:0] e_card = '0;
        logic e_wide = 0, e_attr = 0, e_blk = 0, e_t1 = 0;
        for (int w = 0; w < NW; w++) begin
            if (m_en[w] && m_page[w] == a[31:24] && a[23:12] >= m_lo[w] && a[23:12] <= m_hi[w]) begin
                cnt++;
                if (first < 0) first = w;
            end
        end
        if (!vld) begin first = -1; cnt = 0; end
        if (first >= 0) begin
            e_card = {14'(a[25:12] + m_off[first]), a[11:0]};
            e_wide = m_ctl[first][0];
            e_attr = m_ctl[first][1];
            e_blk  = wr_n & m_ctl[first][2];
            e_t1   = (m_ctl[first][4:3] != 2'b00);
        end
        host_valid = vld; host_write = wr_n; host_addr = a;
        @(posedge clk); @(negedge clk);
        host_valid = 1'b0;
        check("R2 hit", dec_hit, (first >= 0));
        check("R4 index", dec_win, (first >= 0) ? first : 0);
        check("R4 multi", dec_multi, (cnt > 1));
        check("R5 card address", dec_card_addr, e_card);
        check("R6 write block", dec_wr_block, e_blk);
        check("R7 timer set", dec_timer1, e_t1);
        check("R8 size/space", {dec_wide, dec_attr}, {e_wide, e_attr});
    endtask

    initial begin
        for (int w = 0; w < NW; w++) begin
            m_page[w] = 0; m_lo[w] = 0; m_hi[w] = 0; m_off[w] = 0; m_ctl[w] = 0;
        end
        m_en = '0;
        repeat (3) @(negedge clk);
        // R1: reset values at the outputs
        check("R1 reset outputs", {dec_hit, dec_win, dec_card_addr, dec_multi}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 R3: zero config would match page 0 address 0 but nothing is enabled
        probe(32'h0000_0123, 1'b0, 1'b1);

        set_win(0, 8'h12, 12'h100, 12'h1FF, 14'h0010, 8'h05);   // 16-bit, wprot, timer 00
        set_win(1, 8'h12, 12'h180, 12'h2FF, 14'h3FF0, 8'h0A);   // attr, timer 01, wrap offset
        set_win(2, 8'hA0, 12'h000, 12'h000, 14'h1234, 8'h13);   // single page, timer 10
        set_win(3, 8'hFF, 12'hFFF, 12'hFFF, 14'h0001, 8'h1C);   // top page, timer 11, wprot
        set_win(4, 8'h12, 12'h000, 12'hFFF, 14'h2000, 8'h00);   // disabled catch-all
        set_en(5'b01111);

        // R2 R4 R5: sweep pages around both windows, overlap and the disabled span
        for (int p = 12'h0F0; p <= 12'h310; p++) begin
            probe({8'h12, 12'(p), 12'((p * 37) & 12'hFFF)}, 1'(p & 1), 1'b1);
        end
        // R2: single-page window and its neighbours, wrong page
        for (int p = 0; p < 3; p++) begin
            probe({8'hA0, 12'(p), 12'h7FF}, 1'b0, 1'b1);
            probe({8'hA1, 12'(p), 12'h7FF}, 1'b0, 1'b1);
        end
        // R2 R5 R6 R7: top of the address space, read and write
        probe(32'hFFFF_FFFF, 1'b0, 1'b1);
        probe(32'hFFFF_F000, 1'b1, 1'b1);
        probe(32'hFFFF_EFFF, 1'b1, 1'b1);
        // R11: matching address without valid
        probe(32'h1215_0000, 1'b1, 1'b0);
        // R3 R10: enable only the catch-all window, then mask everything
        set_en(5'b10000);
        for (int p = 0; p < 64; p++) probe({8'h12, 12'(p * 64 + 3), 12'h010}, 1'b1, 1'b1);
        set_en(5'b00000);
        probe(32'h1215_0000, 1'b0, 1'b1);
        // R10: rewrite one field (start low of window 0) and re-sweep its lower edge
        set_en(5'b00001);
        m_lo[0] = 12'h140;
        wr(3'd0, 3'd0, 8'h40);
        for (int p = 12'h13E; p <= 12'h142; p++) probe({8'h12, 12'(p), 12'h000}, 1'b0, 1'b1);
        // R9: outputs drop to zero the cycle after the request ends
        @(posedge clk); @(negedge clk);
        check("R9 idle zero", {dec_hit, dec_card_addr}, '0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule